// File: doc/BRIEF.md
# Fully Associative Tag Table with Rotating-Pointer Replacement

This block is a tag store in which every tag may sit in any of its entries (64 by default). A request presents a tag with a valid strobe. In the same cycle, the block compares that tag against every occupied entry. It reports whether a match exists and, if so, which entry holds it. No data is held beside the tags: the block only tracks which tags are resident and where they are.

Replacement uses one rotating pointer, and the pointer is also visible as the victim index. When a request misses and the caller asks for the tag to be installed, the tag is written into the entry under the pointer. The pointer steps forward only when an access lands on the entry it currently names, whether that access is a hit or an install. It steps from the last entry back to entry 0. Entries that keep being used therefore tend to be skipped over, which gives a cheap approximation of least-recently-used eviction. Installs happen only on a miss, so the same tag never occupies two entries.

Top module: `ptr_lru_tag_table`

## Requirements
- R1: After a synchronous active-low reset, no entry is occupied (every lookup misses) and the victim index reads 0.
- R2: When the lookup strobe is high and an occupied entry holds the presented tag, hit is 1 and hit index names that entry, both in the same cycle as the request.
- R3: When the lookup strobe is low, hit is 0 and hit index is 0. Hit index is also 0 whenever hit is 0.
- R4: A strobed lookup that misses while insert enable is high writes the tag into the entry named by the victim index. From the next cycle on, a lookup of that tag hits at that index, and the tag that entry held before no longer hits.
- R5: Such an insert advances the victim index by one on the following clock edge.
- R6: A strobed lookup that hits the entry named by the victim index advances the victim index by one on the following clock edge.
- R7: A strobed lookup that hits any other entry leaves the victim index unchanged.
- R8: The victim index advances from the last entry (63) to entry 0.
- R9: Insert enable during a hit writes nothing. The pointer follows R6 or R7 alone and moves by at most one.
- R10: Insert enable while the lookup strobe is low writes nothing and leaves the victim index unchanged.
- R11: At no time does more than one occupied entry hold the same tag.
- R12: A strobed miss with insert enable low writes nothing and leaves the victim index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lkp_valid | input | 1 | Lookup strobe |
| lkp_tag | input | TAG_W (20) | Tag presented for lookup and for insert |
| ins_en | input | 1 | Install the presented tag if the lookup misses |
| hit | output | 1 | Presented tag is resident |
| hit_idx | output | IDX_W (6) | Entry holding the tag; 0 on a miss |
| victim_idx | output | IDX_W (6) | Entry the pointer names; next install target |

## Verification
Two functions can meet in one cycle: a hit that lands on the entry under the pointer, and an asserted insert enable. The bench fills the table until the pointer wraps to 0. It then looks up the tag resident at the pointer with insert enable held high. It also looks up a resident tag away from the pointer with insert enable high. The per-cycle reference model judges both cases. The pointer must step exactly once in the first case and stay put in the second. In both cases no entry may change, which is confirmed by later lookups of every affected tag.

// File: rtl/ptr_lru_pkg.sv
// Package: shared defaults for the rotating-pointer tag table.
// Assumes: nothing beyond standard SystemVerilog elaboration.
package ptr_lru_pkg;
    parameter int unsigned DEF_ENTRIES = 64;
    parameter int unsigned DEF_TAG_W   = 20;
endpackage

// File: rtl/ptr_lru_tag_array.sv
// Tag array: holds one tag and one occupied bit per entry and compares a
// presented tag against all entries in parallel.
// Assumes: the caller writes only on a miss, so matches stay unique.
module ptr_lru_tag_array #(
    parameter int unsigned ENTRIES = ptr_lru_pkg::DEF_ENTRIES,
    parameter int unsigned TAG_W   = ptr_lru_pkg::DEF_TAG_W,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TAG_W-1:0]   cmp_tag,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    output logic [ENTRIES-1:0] match_vec
);
    logic [ENTRIES-1:0] occ;
    logic [TAG_W-1:0]   tag_mem [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        // Per-entry storage: reset clears occupancy; a write fills the entry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                occ[g] <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                occ[g] <= 1'b1;
            end
        end

        // Per-entry tag register, written alongside the occupied bit.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                tag_mem[g] <= cmp_tag;
            end
        end

        // Per-entry comparator, gated by occupancy.
        always_comb begin
            match_vec[g] = occ[g] && (tag_mem[g] == cmp_tag);
        end
    end

    // R4: a written entry holds the written tag on the next cycle
    a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (occ[$past(wr_idx)] && (tag_mem[$past(wr_idx)] == $past(cmp_tag))));
endmodule

// File: rtl/ptr_lru_first_match.sv
// First-match encoder: returns the lowest set position of a request vector,
// and 0 when no bit is set.
// Assumes: any width of at least two.
module ptr_lru_first_match #(
    parameter int unsigned ENTRIES = ptr_lru_pkg::DEF_ENTRIES,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] req_vec,
    output logic               any,
    output logic [IDX_W-1:0]   first_idx
);
    // Scan from the top down so the lowest set bit is written last.
    always_comb begin
        first_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (req_vec[i]) first_idx = IDX_W'(i);
        end
        any = |req_vec;
    end
endmodule

// File: rtl/ptr_lru_pointer.sv
// Replacement pointer: names the next victim and steps forward, wrapping at
// the last entry, when told that the named entry was accessed.
// Assumes: step is asserted at most once per cycle.
module ptr_lru_pointer #(
    parameter int unsigned ENTRIES = ptr_lru_pkg::DEF_ENTRIES,
    localparam int unsigned IDX_W  = $clog2(ENTRIES),
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [IDX_W-1:0] ptr
);
    // Pointer register: reset to entry 0, step with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (step) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    // R8: stepping from the last entry lands on entry 0
    a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && ptr == LAST) |=> (ptr == '0));
    // R12: without a step the pointer holds
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(ptr));
endmodule

// File: rtl/ptr_lru_tag_table.sv
// Top: fully associative tag table with rotating-pointer replacement.
// A strobed lookup reports hit and the matching entry in the same cycle.
// A miss with insert enable fills the pointed entry. Any access to the
// pointed entry steps the pointer.
// Assumes: ENTRIES is at least 2; insert only ever happens on a miss.
module ptr_lru_tag_table #(
    parameter int unsigned ENTRIES = ptr_lru_pkg::DEF_ENTRIES,
    parameter int unsigned TAG_W   = ptr_lru_pkg::DEF_TAG_W,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lkp_valid,
    input  logic [TAG_W-1:0] lkp_tag,
    input  logic             ins_en,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output logic [IDX_W-1:0] victim_idx
);
    logic [ENTRIES-1:0] match_vec;
    logic               any_match;
    logic [IDX_W-1:0]   first_idx;
    logic               ins_fire;
    logic               step;

    ptr_lru_tag_array #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_tag   (lkp_tag),
        .wr_en     (ins_fire),
        .wr_idx    (victim_idx),
        .match_vec (match_vec)
    );

    ptr_lru_first_match #(.ENTRIES(ENTRIES)) u_enc (
        .req_vec   (match_vec),
        .any       (any_match),
        .first_idx (first_idx)
    );

    ptr_lru_pointer #(.ENTRIES(ENTRIES)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .ptr   (victim_idx)
    );

    // Hit qualification, install decision and pointer step request.
    always_comb begin
        hit      = lkp_valid && any_match;
        hit_idx  = hit ? first_idx : '0;
        ins_fire = lkp_valid && !any_match && ins_en;
        step     = ins_fire || (hit && (first_idx == victim_idx));
    end

    // R11: never more than one entry matches a presented tag
    a_r11_unique: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));
    // R2: a reported hit points at an entry whose comparator fired
    a_r2_idx_matches: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> match_vec[hit_idx]);
    // R3: no strobe, no hit
    a_r3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lkp_valid |-> (!hit && hit_idx == '0));
    // R6: a hit on the pointed entry moves the pointer
    a_r6_step_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && hit_idx == victim_idx) |=> (victim_idx != $past(victim_idx)));
    // R7: a hit elsewhere leaves the pointer alone
    a_r7_stay: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && hit_idx != victim_idx) |=> $stable(victim_idx));
    // R10: insert without strobe has no effect on the pointer
    a_r10_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!lkp_valid && ins_en) |=> $stable(victim_idx));
endmodule

// File: tb/ptr_lru_tag_table_bench.sv
`timescale 1ns/1ps
module ptr_lru_tag_table_bench;
    localparam int N  = 64;
    localparam int TW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lkp_valid = 1'b0;
    logic [TW-1:0] lkp_tag = '0;
    logic          ins_en = 1'b0;
    logic          hit;
    logic [5:0]    hit_idx;
    logic [5:0]    victim_idx;

    int tests = 0;
    int fails = 0;

    // behavioural reference state
    int m_tag [N];
    bit m_vld [N];
    int m_ptr;

    always #4 clk = ~clk;

    ptr_lru_tag_table u_ptr_lru_tag_table (
        .clk(clk), .rst_n(rst_n), .lkp_valid(lkp_valid), .lkp_tag(lkp_tag),
        .ins_en(ins_en), .hit(hit), .hit_idx(hit_idx), .victim_idx(victim_idx)
    );

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_tag[i] = 0; end
        m_ptr = 0;
    endtask

    // One request: drive at negedge, compare before the edge, update model at the edge.
    task automatic op(input bit v, input int t, input bit ins, input string rq);
        bit eh; int ei;
        @(negedge clk);
        lkp_valid = v; lkp_tag = TW'(t); ins_en = ins;
        #1;
        eh = 0; ei = 0;
        if (v) begin
            for (int i = N - 1; i >= 0; i--)
                if (m_vld[i] && m_tag[i] == t) begin eh = 1; ei = i; end
        end
        tests++;
        if (hit !== eh || hit_idx !== 6'(ei) || victim_idx !== 6'(m_ptr)) begin
            fails++;
            $display("FAIL %s: hit/idx/victim = %0d/%0d/%0d expected %0d/%0d/%0d",
                     rq, hit, hit_idx, victim_idx, eh, ei, m_ptr);
        end
        @(posedge clk);
        if (v && eh && ei == m_ptr) m_ptr = (m_ptr + 1) % N;
        else if (v && !eh && ins) begin
            m_tag[m_ptr] = t; m_vld[m_ptr] = 1; m_ptr = (m_ptr + 1) % N;
        end
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        op(1, 5, 0, "R1");                  // empty table, victim 0
        op(1, 100, 1, "R4");                // install at 0
        op(1, 101, 1, "R5");
        op(1, 102, 1, "R5");
        op(1, 103, 1, "R5");
        op(1, 102, 0, "R7");                // hit away from pointer
        op(0, 101, 0, "R3");                // strobe low
        op(1, 101, 1, "R9");                // insert during hit elsewhere
        op(0, 200, 1, "R10");               // insert without strobe
        op(1, 200, 0, "R10");               // 200 must still miss
        op(1, 300, 0, "R12");               // plain miss
        op(1, 300, 0, "R12");
        for (int k = 4; k < N; k++) op(1, 1000 + k, 1, "R4");
        op(1, 7, 0, "R8");                  // pointer wrapped to 0
        op(1, 100, 1, "R9");                // hit on pointer with insert high
        op(1, 1063, 0, "R2");               // last entry still resident
        op(1, 101, 0, "R6");                // hit on pointer entry 1
        op(1, 500, 1, "R4");                // evict entry 2 (tag 102)
        op(1, 102, 0, "R4");                // evicted tag misses
        op(1, 500, 0, "R2");
        for (int k = 0; k < 70; k++) op(1, 2000 + k, 1, "R11");
        for (int k = 0; k < 70; k++) op(1, 2000 + k, 0, "R11");
        @(negedge clk); rst_n = 1'b0; lkp_valid = 1'b0; ins_en = 1'b0;
        @(posedge clk); model_reset();
        @(negedge clk); rst_n = 1'b1;
        op(1, 2069, 0, "R1");
        op(1, 2068, 0, "R1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule